// File: doc/BRIEF.md
# UART Interrupt Arbiter and Identifier

This block gathers the interrupt causes of a UART (line status error, receive data at threshold, receive character timeout, transmit FIFO request, modem status change and auto-baud lock). It gates each cause with its bit in an eight-bit enable register and picks the single highest-ranked pending cause. It presents that cause as a four-bit, 16550-style identification code whose bit 0 is an active-low pending flag. Auto-baud lock is reported on a flag of its own, outside the ranking. A combined interrupt line goes to the system interrupt controller.

Software writes the enable register through `ier_wr`/`ier_wdata` and reads it back on `ier_q`. The surrounding register decoder turns its accesses into strobes: `lsr_rd`, `msr_rd`, `iir_rd` and `tx_wr`. These strobes clear the matching causes.

Two small state machines hold the causes that need memory.

- **Transmit request machine**, with states TX_IDLE, TX_PEND and TX_ACKED:
  - TX_IDLE→TX_PEND when `tx_req` is high.
  - TX_PEND→TX_ACKED on `tx_wr`, or on `iir_rd` while the code shows the transmit request.
  - TX_PEND→TX_IDLE when `tx_req` drops.
  - TX_ACKED→TX_IDLE when `tx_req` drops.
- **Timeout machine**, with states TO_IDLE and TO_PEND:
  - TO_IDLE→TO_PEND on `rx_timeout_evt` with no `rx_char` in the same cycle.
  - TO_PEND→TO_IDLE on `rx_char`.

Line status and modem status are single sticky flags. The FIFOs, the baud generator, bus decoding and DMA are outside the block. Only their status signals and the DMA enable bit are used.

Top module: `uart_irq_arbiter`

## Requirements
- R1: The enable register resets to 8'h00 and loads `ier_wdata` on the clock edge where `ier_wr` is high. Its bit map is: 0 receive data enable, 1 transmit request enable, 2 line status enable, 3 modem enable, 4 timeout enable, 5 NRZ (stored only), 6 unit enable, 7 DMA enable. `ier_q` shows the stored value.
- R2: The identification code shows only the highest-ranked enabled pending cause. The ranking is: line status 4'b0110, then receive data 4'b0100, then timeout 4'b1100, then transmit request 4'b0010, then modem 4'b0000. Receive data and timeout share one level, and receive data wins when both are pending.
- R3: When no enabled cause is pending, the code is 4'b0001. Whenever bit 0 of the code is 1, bits 3:1 are 0.
- R4: `abl_flag` follows `abl_lock` one cycle later and never alters the identification code.
- R5: After an `rx_timeout_evt` pulse, the timeout cause stays pending until an `rx_char` pulse clears it. An `rx_timeout_evt` in the same cycle as `rx_char` is ignored.
- R6: The receive data cause is pending exactly while `rx_level_hit` is high and enable bit 0 is 1.
- R7: While DMA enable (bit 7) is 1, the receive data and transmit request causes are masked. `dma_conflict` is high while bit 7 and either bit 0 or bit 1 are 1.
- R8: A line status error stays pending until `lsr_rd`. A modem change stays pending until `msr_rd`. A new event in the same cycle as the read keeps the cause pending.
- R9: The transmit request is cleared by `tx_wr`, or by `iir_rd` while code 4'b0010 is shown. After a clear it does not return until `tx_req` has gone low and high again. An `iir_rd` while another code is shown leaves it pending.
- R10: `irq` is high exactly when unit enable (bit 6) is 1 and either code bit 0 is 0 or `abl_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| lsr_err | input | 1 | Line status error event pulse |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_change | input | 1 | Modem status change pulse |
| msr_rd | input | 1 | Modem status register read strobe |
| rx_level_hit | input | 1 | Receive FIFO at or above trigger level |
| rx_char | input | 1 | Character received pulse |
| rx_timeout_evt | input | 1 | Character timeout detected pulse |
| tx_req | input | 1 | Transmit FIFO at or below its request level |
| tx_wr | input | 1 | Transmit FIFO write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| abl_lock | input | 1 | Auto-baud lock status |
| ier_q | output | 8 | Stored enable register |
| iir_code | output | 4 | Identification code, bit 0 active-low pending |
| abl_flag | output | 1 | Auto-baud lock flag |
| irq | output | 1 | Combined interrupt output |
| dma_conflict | output | 1 | DMA enabled together with a data interrupt enable |

## Verification
The assertions check the following on every cycle:
- the shape of the idle code;
- that the line status cause always wins;
- that DMA enable keeps the data codes off the output;
- that the interrupt line is held low without unit enable, and is raised by the lock flag;
- the single-step clears of the timeout and line status causes;
- that an acknowledged transmit request does not re-arm while its level stays high.

Only the bench's scenarios can show the full ranking over every mix of enables and causes, the DMA conflict flag and the enable register contents. They also cover the same-cycle collisions of events with reads, and the complete transmit request life cycle across both clear strobes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int IER_W = 8;
    localparam int ID_W  = 4;

    localparam int EN_RXDATA  = 0;
    localparam int EN_TXREQ   = 1;
    localparam int EN_LINE    = 2;
    localparam int EN_MODEM   = 3;
    localparam int EN_TIMEOUT = 4;
    localparam int EN_NRZ     = 5;
    localparam int EN_UNIT    = 6;
    localparam int EN_DMA     = 7;

    typedef enum logic [ID_W-1:0] {
        ID_MODEM   = 4'b0000,
        ID_NONE    = 4'b0001,
        ID_TXREQ   = 4'b0010,
        ID_RXDATA  = 4'b0100,
        ID_LINE    = 4'b0110,
        ID_TIMEOUT = 4'b1100
    } irq_id_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'b00,
        TX_PEND  = 2'b01,
        TX_ACKED = 2'b10
    } tx_state_e;

    typedef enum logic {
        TO_IDLE = 1'b0,
        TO_PEND = 1'b1
    } to_state_e;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic timeout;
        logic txreq;
        logic modem;
    } src_vec_t;
endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [IER_W-1:0] wdata,
    output logic [IER_W-1:0] ier_q,
    output src_vec_t         en,
    output logic             unit_en,
    output logic             dma_conflict
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_q <= '0;
        end else if (wr) begin
            ier_q <= wdata;
        end
    end

    always_comb begin
        en.line      = ier_q[EN_LINE];
        en.rxdata    = ier_q[EN_RXDATA] & ~ier_q[EN_DMA];
        en.timeout   = ier_q[EN_TIMEOUT];
        en.txreq     = ier_q[EN_TXREQ] & ~ier_q[EN_DMA];
        en.modem     = ier_q[EN_MODEM];
        unit_en      = ier_q[EN_UNIT];
        dma_conflict = ier_q[EN_DMA] & (ier_q[EN_RXDATA] | ier_q[EN_TXREQ]);
    end
endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lsr_err,
    input  logic     lsr_rd,
    input  logic     msr_change,
    input  logic     msr_rd,
    input  logic     rx_level_hit,
    input  logic     rx_char,
    input  logic     rx_timeout_evt,
    input  logic     tx_req,
    input  logic     tx_wr,
    input  logic     iir_rd,
    input  logic     tx_shown,
    input  logic     abl_lock,
    output src_vec_t raw,
    output logic     abl_flag
);
    tx_state_e tx_q, tx_d;
    to_state_e to_q, to_d;
    logic      line_q, line_d;
    logic      modem_q, modem_d;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q     <= TX_IDLE;
            to_q     <= TO_IDLE;
            line_q   <= 1'b0;
            modem_q  <= 1'b0;
            abl_flag <= 1'b0;
        end else begin
            tx_q     <= tx_d;
            to_q     <= to_d;
            line_q   <= line_d;
            modem_q  <= modem_d;
            abl_flag <= abl_lock;
        end
    end

    // next-state process
    always_comb begin
        tx_d = tx_q;
        unique case (tx_q)
            TX_IDLE:  if (tx_req) tx_d = TX_PEND;
            TX_PEND: begin
                if (tx_wr || (iir_rd && tx_shown)) tx_d = TX_ACKED;
                else if (!tx_req)                  tx_d = TX_IDLE;
            end
            TX_ACKED: if (!tx_req) tx_d = TX_IDLE;
            default:  tx_d = TX_IDLE;
        endcase

        to_d = to_q;
        unique case (to_q)
            TO_IDLE: if (rx_timeout_evt && !rx_char) to_d = TO_PEND;
            TO_PEND: if (rx_char)                    to_d = TO_IDLE;
            default: to_d = TO_IDLE;
        endcase

        line_d  = lsr_err | (line_q & ~lsr_rd);
        modem_d = msr_change | (modem_q & ~msr_rd);
    end

    // output process
    always_comb begin
        raw.line    = line_q;
        raw.rxdata  = rx_level_hit;
        raw.timeout = (to_q == TO_PEND);
        raw.txreq   = (tx_q == TX_PEND);
        raw.modem   = modem_q;
    end

    p_timeout_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (to_q == TO_PEND && rx_char) |=> (to_q == TO_IDLE));

    p_line_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q && lsr_rd && !lsr_err) |=> !line_q);

    p_tx_no_refire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q == TX_ACKED && tx_req) |=> (tx_q != TX_PEND));
endmodule

// File: rtl/uart_irq_encoder.sv
module uart_irq_encoder
    import uart_irq_pkg::*;
(
    input  src_vec_t pend,
    output irq_id_e  code
);
    always_comb begin
        if (pend.line)         code = ID_LINE;
        else if (pend.rxdata)  code = ID_RXDATA;
        else if (pend.timeout) code = ID_TIMEOUT;
        else if (pend.txreq)   code = ID_TXREQ;
        else if (pend.modem)   code = ID_MODEM;
        else                   code = ID_NONE;
    end
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [IER_W-1:0] ier_wdata,
    input  logic             lsr_err,
    input  logic             lsr_rd,
    input  logic             msr_change,
    input  logic             msr_rd,
    input  logic             rx_level_hit,
    input  logic             rx_char,
    input  logic             rx_timeout_evt,
    input  logic             tx_req,
    input  logic             tx_wr,
    input  logic             iir_rd,
    input  logic             abl_lock,
    output logic [IER_W-1:0] ier_q,
    output logic [ID_W-1:0]  iir_code,
    output logic             abl_flag,
    output logic             irq,
    output logic             dma_conflict
);
    src_vec_t en;
    src_vec_t raw;
    src_vec_t pend;
    logic     unit_en;
    irq_id_e  code;
    logic     tx_shown;

    uart_irq_enable_reg u_enable (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (ier_wr),
        .wdata        (ier_wdata),
        .ier_q        (ier_q),
        .en           (en),
        .unit_en      (unit_en),
        .dma_conflict (dma_conflict)
    );

    uart_irq_sources u_sources (
        .clk            (clk),
        .rst_n          (rst_n),
        .lsr_err        (lsr_err),
        .lsr_rd         (lsr_rd),
        .msr_change     (msr_change),
        .msr_rd         (msr_rd),
        .rx_level_hit   (rx_level_hit),
        .rx_char        (rx_char),
        .rx_timeout_evt (rx_timeout_evt),
        .tx_req         (tx_req),
        .tx_wr          (tx_wr),
        .iir_rd         (iir_rd),
        .tx_shown       (tx_shown),
        .abl_lock       (abl_lock),
        .raw            (raw),
        .abl_flag       (abl_flag)
    );

    assign pend = raw & en;

    uart_irq_encoder u_encoder (
        .pend (pend),
        .code (code)
    );

    assign iir_code = code;
    assign tx_shown = (code == ID_TXREQ);
    assign irq      = unit_en & (~iir_code[0] | abl_flag);

    p_line_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raw.line && ier_q[EN_LINE]) |-> (iir_code == 4'b0110));

    p_idle_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        iir_code[0] |-> (iir_code[3:1] == 3'b000));

    p_abl_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (abl_flag && ier_q[EN_UNIT]) |-> irq);

    p_dma_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ier_q[EN_DMA] |-> (iir_code != 4'b0100 && iir_code != 4'b0010));

    p_unit_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_q[EN_UNIT] |-> !irq);
endmodule

// File: tb/uart_irq_arbiter_test.sv
`timescale 1ns/1ps
module uart_irq_arbiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 0;
    logic [7:0] ier_wdata = 0;
    logic       lsr_err = 0, lsr_rd = 0, msr_change = 0, msr_rd = 0;
    logic       rx_level_hit = 0, rx_char = 0, rx_timeout_evt = 0;
    logic       tx_req = 0, tx_wr = 0, iir_rd = 0, abl_lock = 0;
    logic [7:0] ier_q;
    logic [3:0] iir_code;
    logic       abl_flag, irq, dma_conflict;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    uart_irq_arbiter uut (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .lsr_err(lsr_err), .lsr_rd(lsr_rd), .msr_change(msr_change), .msr_rd(msr_rd),
        .rx_level_hit(rx_level_hit), .rx_char(rx_char), .rx_timeout_evt(rx_timeout_evt),
        .tx_req(tx_req), .tx_wr(tx_wr), .iir_rd(iir_rd), .abl_lock(abl_lock),
        .ier_q(ier_q), .iir_code(iir_code), .abl_flag(abl_flag), .irq(irq),
        .dma_conflict(dma_conflict)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        {lsr_err, lsr_rd, msr_change, msr_rd, rx_level_hit, rx_char} = '0;
        {rx_timeout_evt, tx_req, tx_wr, iir_rd, abl_lock, ier_wr} = '0;
        step();
        rst_n = 1;
    endtask

    task automatic write_ier(input logic [7:0] v);
        ier_wr = 1; ier_wdata = v;
        step();
        ier_wr = 0;
    endtask

    function automatic logic [3:0] model_code(input logic [4:0] en, input logic dma,
                                              input logic [4:0] s);
        // en: 0 rxdata, 1 txreq, 2 line, 3 modem, 4 timeout
        // s : 0 line, 1 rxlevel, 2 timeout, 3 txreq, 4 modem
        if (s[0] && en[2])              return 4'b0110;
        if (s[1] && en[0] && !dma)      return 4'b0100;
        if (s[2] && en[4])              return 4'b1100;
        if (s[3] && en[1] && !dma)      return 4'b0010;
        if (s[4] && en[3])              return 4'b0000;
        return 4'b0001;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        step();
        // R1 reset state
        chk("R1 ier reset", ier_q, 8'h00);
        chk("R3 idle code", {4'h0, iir_code}, 8'h01);
        chk("R10 irq reset", {7'h0, irq}, 8'h00);
        chk("R4 abl reset", {7'h0, abl_flag}, 8'h00);

        // exhaustive sweep: enables x dma x unit x causes x lock
        for (int c = 0; c < 8192; c++) begin
            logic [4:0] en;
            logic       dma, unit, ab;
            logic [4:0] s;
            logic [3:0] exp_code;
            logic [7:0] iv;
            en = c[4:0]; dma = c[5]; unit = c[6]; s = c[11:7]; ab = c[12];
            iv = {dma, unit, 1'b0, en};
            do_reset();
            write_ier(iv);
            lsr_err = s[0]; rx_level_hit = s[1]; rx_timeout_evt = s[2];
            tx_req = s[3]; msr_change = s[4]; abl_lock = ab;
            step();
            lsr_err = 0; rx_timeout_evt = 0; msr_change = 0;
            exp_code = model_code(en, dma, s);
            chk("R1 ier readback", ier_q, iv);
            chk("R2 R6 ranked code", {4'h0, iir_code}, {4'h0, exp_code});
            chk("R7 dma conflict", {7'h0, dma_conflict}, {7'h0, dma & (en[0] | en[1])});
            chk("R4 abl flag", {7'h0, abl_flag}, {7'h0, ab});
            chk("R10 irq", {7'h0, irq}, {7'h0, unit & ((exp_code != 4'b0001) | ab)});
        end

        // R5 timeout set and cleared by new character
        do_reset(); write_ier(8'h50);
        rx_timeout_evt = 1; step(); rx_timeout_evt = 0;
        chk("R5 timeout pending", {4'h0, iir_code}, 8'h0C);
        step();
        chk("R5 timeout held", {4'h0, iir_code}, 8'h0C);
        rx_char = 1; step(); rx_char = 0;
        chk("R5 timeout cleared", {4'h0, iir_code}, 8'h01);
        rx_timeout_evt = 1; rx_char = 1; step(); rx_timeout_evt = 0; rx_char = 0;
        chk("R5 timeout with char ignored", {4'h0, iir_code}, 8'h01);

        // R6 receive data follows level
        do_reset(); write_ier(8'h41);
        rx_level_hit = 1; step();
        chk("R6 rx data shown", {4'h0, iir_code}, 8'h04);
        rx_level_hit = 0; step();
        chk("R6 rx data gone", {4'h0, iir_code}, 8'h01);

        // R8 line status and modem clears
        do_reset(); write_ier(8'h4C);
        lsr_err = 1; msr_change = 1; step(); lsr_err = 0; msr_change = 0;
        chk("R8 line shown", {4'h0, iir_code}, 8'h06);
        lsr_rd = 1; lsr_err = 1; step(); lsr_rd = 0; lsr_err = 0;
        chk("R8 line kept on collision", {4'h0, iir_code}, 8'h06);
        lsr_rd = 1; step(); lsr_rd = 0;
        chk("R8 modem after line read", {4'h0, iir_code}, 8'h00);
        msr_rd = 1; step(); msr_rd = 0;
        chk("R8 modem cleared", {4'h0, iir_code}, 8'h01);

        // R9 transmit request life cycle
        do_reset(); write_ier(8'h46);
        tx_req = 1; lsr_err = 1; step(); lsr_err = 0;
        chk("R9 line above tx", {4'h0, iir_code}, 8'h06);
        iir_rd = 1; step(); iir_rd = 0;
        chk("R9 tx survives other read", {4'h0, iir_code}, 8'h06);
        lsr_rd = 1; step(); lsr_rd = 0;
        chk("R9 tx shown", {4'h0, iir_code}, 8'h02);
        iir_rd = 1; step(); iir_rd = 0;
        chk("R9 tx cleared by iir read", {4'h0, iir_code}, 8'h01);
        step();
        chk("R9 tx not refired", {4'h0, iir_code}, 8'h01);
        tx_req = 0; step(); tx_req = 1; step();
        chk("R9 tx rearmed", {4'h0, iir_code}, 8'h02);
        tx_wr = 1; step(); tx_wr = 0;
        chk("R9 tx cleared by write", {4'h0, iir_code}, 8'h01);
        chk("R10 irq low after clear", {7'h0, irq}, 8'h00);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule